// File: doc/BRIEF.md
# Bit-Plane Codeword Pattern Encoder

This block takes the transformed bit-plane codewords of one cache line, one codeword per cycle and in order, and turns each into a variable-length symbol. A symbol is a prefix that no other symbol starts with, followed by an argument only when the pattern needs one. Consecutive zero codewords are not emitted one by one. A counter collects them, and the whole run is sent as a single run symbol. The run ends when a non-zero codeword arrives, when the counter fills, or when the line ends.

Each input codeword comes with a flag that marks a plane that was already zero before the XOR step. Such a plane is sent as a short zero-plane code even when its XORed value is non-zero. All-ones planes, planes with one set bit and planes with one adjacent pair of set bits also have short dedicated codes. Any other plane is sent raw behind a one-bit escape.

One input cycle can produce two symbols: a run that just closed and the symbol for the current codeword. The block therefore has two output lanes. When both are valid in the same cycle, the run lane comes first in the stream. Codes are right-aligned in their field, and the length port gives how many low bits are meaningful. The first bit sent is the most significant of those bits. A downstream packer concatenates the symbols.

Top module: `bpc_plane_encoder`

## Requirements
- R1: After reset, and before any codeword is accepted, `run_valid` and `pat_valid` are low.
- R2: The symbols produced by a codeword accepted with `in_valid` high appear on the outputs exactly one clock later. When both lanes are valid in the same cycle, the run symbol comes before the pattern symbol.
- R3: A zero codeword (`in_plane` all zero) emits no pattern symbol. It extends the pending run, whatever `in_prexor_zero` says. When a non-zero codeword arrives, a pending run of length L is emitted on the run lane as code 001 followed by the 5-bit value L-1, with length 8.
- R4: When the 32nd consecutive zero codeword is accepted, the run is emitted in the same cycle with count field 11111, and counting restarts from zero.
- R5: When `in_last` is high on a zero codeword, the pending run, including that codeword, is emitted on that codeword's cycle. No run carries over into the next line.
- R6: A non-zero codeword with `in_prexor_zero` high is emitted as code 00001, length 5. This has priority over every other pattern.
- R7: An all-ones codeword, when R6 does not apply, is emitted as code 00000, length 5.
- R8: A codeword with exactly one set bit at position p is emitted as 00011 followed by p in 5 bits, length 10.
- R9: A codeword whose only set bits are two adjacent bits p and p+1 is emitted as 00010 followed by p in 5 bits, length 10.
- R10: Any other non-zero codeword is emitted as a 1 followed by the 31 codeword bits, MSB first, length 32.
- R11: A cycle with `in_valid` low emits nothing and leaves a pending run unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A codeword is presented this cycle |
| in_plane | input | 31 | XORed bit-plane codeword |
| in_prexor_zero | input | 1 | The plane was zero before the XOR step |
| in_last | input | 1 | Last codeword of the line |
| run_valid | output | 1 | A zero-run symbol is present |
| run_code | output | 32 | Run symbol, right-aligned |
| run_len | output | 6 | Bit length of the run symbol |
| pat_valid | output | 1 | A pattern symbol is present |
| pat_code | output | 32 | Pattern symbol, right-aligned |
| pat_len | output | 6 | Bit length of the pattern symbol |

## Verification
A corrupted run counter shows up as a wrong count field. It appears in the cycle after the next non-zero codeword, at the saturation point, or at the end of the line, so long random runs across idle gaps are checked field by field. A wrong priority in the classifier shows up at once as a wrong prefix or length on the pattern lane. The stimulus therefore mixes planes that match several patterns at once, such as all-ones or single-bit planes with the pre-XOR flag set, and zero planes with the flag set.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
    typedef enum logic [2:0] {
        K_PREXOR = 3'd0,
        K_ONES   = 3'd1,
        K_SINGLE = 3'd2,
        K_DOUBLE = 3'd3,
        K_RAW    = 3'd4
    } kind_e;

    localparam logic [2:0] PFX_RUN    = 3'b001;
    localparam logic [4:0] PFX_PREXOR = 5'b00001;
    localparam logic [4:0] PFX_ONES   = 5'b00000;
    localparam logic [4:0] PFX_SINGLE = 5'b00011;
    localparam logic [4:0] PFX_DOUBLE = 5'b00010;
endpackage

// File: rtl/bpc_classify.sv
module bpc_classify
    import bpc_pkg::*;
#(
    parameter int CW = 31,
    localparam int PW = $clog2(CW)
) (
    input  logic [CW-1:0] plane,
    input  logic          prexor_zero,
    output kind_e         kind,
    output logic [PW-1:0] pos
);
    logic          is_single;
    logic          is_double;
    logic [PW-1:0] single_pos;
    logic [PW-1:0] double_pos;

    always_comb begin
        is_single  = (plane != '0) && ((plane & (plane - CW'(1))) == '0);
        single_pos = '0;
        for (int i = 0; i < CW; i++) begin
            if (plane[i]) single_pos = PW'(i);
        end
        is_double  = 1'b0;
        double_pos = '0;
        for (int k = 0; k < CW - 1; k++) begin
            if (plane == (CW'(3) << k)) begin
                is_double  = 1'b1;
                double_pos = PW'(k);
            end
        end
    end

    always_comb begin
        pos = '0;
        if (prexor_zero) begin
            kind = K_PREXOR;
        end else if (&plane) begin
            kind = K_ONES;
        end else if (is_single) begin
            kind = K_SINGLE;
            pos  = single_pos;
        end else if (is_double) begin
            kind = K_DOUBLE;
            pos  = double_pos;
        end else begin
            kind = K_RAW;
        end
    end
endmodule

// File: rtl/bpc_sym_build.sv
module bpc_sym_build
    import bpc_pkg::*;
#(
    parameter int CW = 31,
    parameter int RW = 5,
    localparam int PW   = $clog2(CW),
    localparam int SYMW = CW + 1,
    localparam int LW   = $clog2(SYMW + 1)
) (
    input  kind_e           kind,
    input  logic [PW-1:0]   pos,
    input  logic [CW-1:0]   plane,
    input  logic [RW:0]     run_count,
    output logic [SYMW-1:0] pat_code,
    output logic [LW-1:0]   pat_len,
    output logic [SYMW-1:0] run_code,
    output logic [LW-1:0]   run_len
);
    logic [RW:0] run_m1;

    always_comb begin
        run_m1   = run_count - (RW+1)'(1);
        run_code = SYMW'({PFX_RUN, run_m1[RW-1:0]});
        run_len  = LW'(3 + RW);
        case (kind)
            K_PREXOR: begin
                pat_code = SYMW'(PFX_PREXOR);
                pat_len  = LW'(5);
            end
            K_ONES: begin
                pat_code = SYMW'(PFX_ONES);
                pat_len  = LW'(5);
            end
            K_SINGLE: begin
                pat_code = SYMW'({PFX_SINGLE, pos});
                pat_len  = LW'(5 + PW);
            end
            K_DOUBLE: begin
                pat_code = SYMW'({PFX_DOUBLE, pos});
                pat_len  = LW'(5 + PW);
            end
            default: begin
                pat_code = {1'b1, plane};
                pat_len  = LW'(SYMW);
            end
        endcase
    end
endmodule

// File: rtl/bpc_plane_encoder.sv
module bpc_plane_encoder
    import bpc_pkg::*;
#(
    parameter int CW = 31,
    parameter int RW = 5,
    localparam int PW   = $clog2(CW),
    localparam int SYMW = CW + 1,
    localparam int LW   = $clog2(SYMW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [CW-1:0]   in_plane,
    input  logic            in_prexor_zero,
    input  logic            in_last,
    output logic            run_valid,
    output logic [SYMW-1:0] run_code,
    output logic [LW-1:0]   run_len,
    output logic            pat_valid,
    output logic [SYMW-1:0] pat_code,
    output logic [LW-1:0]   pat_len
);
    localparam logic [RW:0] RUN_MAX = (RW+1)'(1) << RW;

    typedef struct packed {
        logic [RW:0]     cnt;
        logic            run_v;
        logic [SYMW-1:0] run_c;
        logic [LW-1:0]   run_l;
        logic            pat_v;
        logic [SYMW-1:0] pat_c;
        logic [LW-1:0]   pat_l;
    } state_t;

    state_t st_d, st_q;

    kind_e           kind;
    logic [PW-1:0]   pos;
    logic [RW:0]     run_count;
    logic [SYMW-1:0] b_pat_code, b_run_code;
    logic [LW-1:0]   b_pat_len, b_run_len;
    logic [RW:0]     cnt_inc;
    logic            is_zero;

    bpc_classify #(.CW(CW)) u_cls (
        .plane       (in_plane),
        .prexor_zero (in_prexor_zero),
        .kind        (kind),
        .pos         (pos)
    );

    bpc_sym_build #(.CW(CW), .RW(RW)) u_bld (
        .kind      (kind),
        .pos       (pos),
        .plane     (in_plane),
        .run_count (run_count),
        .pat_code  (b_pat_code),
        .pat_len   (b_pat_len),
        .run_code  (b_run_code),
        .run_len   (b_run_len)
    );

    assign is_zero   = (in_plane == '0);
    assign cnt_inc   = st_q.cnt + (RW+1)'(1);
    assign run_count = is_zero ? cnt_inc : st_q.cnt;

    always_comb begin
        st_d       = st_q;
        st_d.run_v = 1'b0;
        st_d.pat_v = 1'b0;
        st_d.run_c = b_run_code;
        st_d.run_l = b_run_len;
        st_d.pat_c = b_pat_code;
        st_d.pat_l = b_pat_len;
        if (in_valid) begin
            if (is_zero) begin
                if (cnt_inc == RUN_MAX || in_last) begin
                    st_d.run_v = 1'b1;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt   = cnt_inc;
                end
            end else begin
                st_d.run_v = (st_q.cnt != '0);
                st_d.pat_v = 1'b1;
                st_d.cnt   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_valid = st_q.run_v;
    assign run_code  = st_q.run_c;
    assign run_len   = st_q.run_l;
    assign pat_valid = st_q.pat_v;
    assign pat_code  = st_q.pat_c;
    assign pat_len   = st_q.pat_l;
endmodule

// File: rtl/bpc_plane_encoder_chk.sv
module bpc_plane_encoder_chk #(
    parameter int CW = 31,
    parameter int RW = 5,
    localparam int SYMW = CW + 1,
    localparam int LW   = $clog2(SYMW + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [CW-1:0]   in_plane,
    input logic            in_prexor_zero,
    input logic            in_last,
    input logic            run_valid,
    input logic [SYMW-1:0] run_code,
    input logic [LW-1:0]   run_len,
    input logic            pat_valid,
    input logic [SYMW-1:0] pat_code,
    input logic [LW-1:0]   pat_len
);
    // R11
    idle_no_symbol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_valid || pat_valid) |-> $past(in_valid));

    // R3
    zero_no_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pat_valid |-> ($past(in_plane) != '0));

    // R5
    eol_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last && in_plane == '0) |=> run_valid);

    // R6
    prexor_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_valid && $past(in_prexor_zero)) |-> (pat_len == LW'(5) && pat_code == SYMW'(1)));

    // R10
    raw_escape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_valid && pat_len == LW'(SYMW)) |-> (pat_code[SYMW-1] && pat_code[CW-1:0] == $past(in_plane)));

    // R3
    run_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_valid |-> (run_len == LW'(3 + RW) && run_code[RW+2:RW] == 3'b001));
endmodule

bind bpc_plane_encoder bpc_plane_encoder_chk #(.CW(CW), .RW(RW)) u_chk (.*);

// File: tb/sim_bpc_plane_encoder.sv
module sim_bpc_plane_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 31;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [CW-1:0] in_plane = '0;
    logic          in_prexor_zero = 1'b0;
    logic          in_last = 1'b0;
    logic          run_valid, pat_valid;
    logic [31:0]   run_code, pat_code;
    logic [5:0]    run_len, pat_len;

    int checks = 0;
    int fails = 0;
    int ref_cnt = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bpc_plane_encoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_plane(in_plane),
        .in_prexor_zero(in_prexor_zero), .in_last(in_last),
        .run_valid(run_valid), .run_code(run_code), .run_len(run_len),
        .pat_valid(pat_valid), .pat_code(pat_code), .pat_len(pat_len)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic void exp_pattern(input logic [CW-1:0] p, input logic pz,
                                        output logic [31:0] code, output int len, output string tag);
        int n = 0;
        int lo = -1;
        for (int i = 0; i < CW; i++) if (p[i]) begin
            n++;
            if (lo < 0) lo = i;
        end
        if (pz) begin code = 32'h1; len = 5; tag = "R6"; end
        else if (n == CW) begin code = 32'h0; len = 5; tag = "R7"; end
        else if (n == 1) begin code = (32'b00011 << 5) | lo; len = 10; tag = "R8"; end
        else if (n == 2 && lo < CW-1 && p[lo+1]) begin code = (32'b00010 << 5) | lo; len = 10; tag = "R9"; end
        else begin code = {1'b1, p}; len = 32; tag = "R10"; end
    endfunction

    task automatic step(input logic v, input logic [CW-1:0] p, input logic pz, input logic last);
        bit er = 0, ep = 0;
        logic [31:0] rc = '0, pc = '0;
        int pl = 0;
        string rtag = "R11", ptag = "R11";
        in_valid = v; in_plane = p; in_prexor_zero = pz; in_last = last;
        if (v) begin
            if (p == '0) begin
                int c = ref_cnt + 1;
                if (c == 32 || last) begin
                    er = 1; rc = 32'(8'b00100000 | (c - 1));
                    rtag = (c == 32) ? "R4" : "R5";
                    ref_cnt = 0;
                end else ref_cnt = c;
            end else begin
                if (ref_cnt > 0) begin
                    er = 1; rc = 32'(8'b00100000 | (ref_cnt - 1)); rtag = "R3";
                end
                ep = 1;
                exp_pattern(p, pz, pc, pl, ptag);
                ref_cnt = 0;
            end
        end
        @(negedge clk);
        chk((er || ep) ? "R2" : "R11", "run_valid", longint'(run_valid), longint'(er));
        chk((er || ep) ? "R2" : "R11", "pat_valid", longint'(pat_valid), longint'(ep));
        if (er && run_valid) begin
            chk(rtag, "run_code", longint'(run_code), longint'(rc));
            chk(rtag, "run_len", longint'(run_len), 64'd8);
        end
        if (ep && pat_valid) begin
            chk(ptag, "pat_code", longint'(pat_code), longint'(pc));
            chk(ptag, "pat_len", longint'(pat_len), longint'(pl));
        end
        in_valid = 1'b0;
    endtask

    function automatic logic [CW-1:0] rand_plane(output logic pz);
        int r = int'($urandom % 8);
        logic [CW-1:0] m = CW'($urandom);
        int k = int'($urandom % (CW - 1));
        pz = 1'b0;
        case (r)
            0, 1, 2: begin pz = ($urandom % 2) == 1; return '0; end
            3: begin pz = 1'b1; return m | CW'(1); end
            4: return '1;
            5: return CW'(1) << k;
            6: return CW'(3) << k;
            default: return m;
        endcase
    endfunction

    initial begin
        logic pz;
        logic [CW-1:0] p;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "run_valid after reset", longint'(run_valid), 0);
        chk("R1", "pat_valid after reset", longint'(pat_valid), 0);

        // R3 run of 3 then single one; R8
        step(1, '0, 0, 0); step(1, '0, 1, 0); step(1, '0, 0, 0);
        step(1, CW'(1) << 7, 0, 0);
        // R11 idle keeps run
        step(1, '0, 0, 0); step(0, '0, 0, 0); step(0, '1, 0, 0); step(1, '0, 0, 0);
        step(1, CW'(3) << 29, 0, 0); // R9 top pair
        // R6 priority over all-ones and single
        step(1, '1, 1, 0); step(1, CW'(1), 1, 0);
        step(1, '1, 0, 0);            // R7
        step(1, CW'(5), 0, 0);        // R10 non-adjacent pair
        step(1, CW'(1) << 30, 0, 0);  // R8 top bit
        // R4 saturation at 32, then one more zero flushed at end of line (R5)
        for (int i = 0; i < 33; i++) step(1, '0, 0, i == 32);
        // R5 single zero at end of line
        step(1, '0, 0, 1);
        // R3 run then non-zero last codeword
        step(1, '0, 0, 0); step(1, CW'(6), 0, 1);

        for (int line = 0; line < 300; line++) begin
            for (int j = 0; j < 32; j++) begin
                if ($urandom % 10 == 0) step(0, CW'($urandom), 0, 0);
                p = rand_plane(pz);
                step(1, p, pz, j == 31);
            end
        end
        step(0, '0, 0, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule